// File: doc/BRIEF.md
# Handshaked Serial Command Receiver

This block receives short command messages from a host controller over a four-wire handshake on the slave side. The host raises a request line and shifts bytes in on a serial data line with its own transfer clock. It then pulses a ready line to close the message. The block answers on an acknowledge line that is high from the accepted request until the ready pulse. All host lines are asynchronous to the system clock, so each one first crosses a two-flop synchronizer. Edge detection happens after the synchronizer.

The block assembles the bits into bytes and stores them in a small message buffer. When the message closes, it raises a one-cycle completion strobe. With the strobe it presents the count of whole bytes and an error flag. The flag reports a trailing partial byte or a message longer than the buffer. Downstream logic reads the stored bytes from a flat output vector. Interpreting the commands is left to that logic.

Top module: `cmd_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released, `host_ack`, `msg_done`, `msg_len` and `msg_err` are all 0.
- R2: While a message is open, each synchronized rising edge of `host_sclk` shifts in one `host_sdata` bit, most significant bit first. Every eighth bit completes a byte. The k-th complete byte of a message (k from 0) appears on `msg_data[8k+7:8k]`.
- R3: A rising edge of `host_req` while idle opens a message. `host_ack` becomes 1 at the second clock edge after the first edge that samples `host_req` high.
- R4: A rising edge of `host_req` while a message is open has no effect. Rising edges of `host_sclk` while idle shift in nothing.
- R5: A rising edge of `host_rdy` while a message is open closes it. `host_ack` falls and `msg_done` is 1 for exactly one cycle, with the same two-edge latency as in R3.
- R6: When `msg_done` is high, `msg_len` equals the number of complete bytes received, saturated at DEPTH (8).
- R7: If the message closes with 1 to 7 bits of an unfinished byte, those bits are discarded and `msg_err` is 1.
- R8: Bytes beyond DEPTH are dropped, the stored bytes stay as written, `msg_len` is DEPTH and `msg_err` is 1.
- R9: `msg_len` and `msg_err` keep their values from the last completion until the next completion.
- R10: A rising edge of `host_rdy` while idle produces no `msg_done` and changes neither `msg_len` nor `msg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host request, asynchronous |
| host_sclk | input | 1 | Host transfer clock, asynchronous |
| host_sdata | input | 1 | Host serial data, asynchronous |
| host_rdy | input | 1 | Host transfer-finished pulse, asynchronous |
| host_ack | output | 1 | High while a message is open |
| msg_done | output | 1 | One-cycle message completion strobe |
| msg_len | output | $clog2(DEPTH+1) | Complete bytes in the last message |
| msg_err | output | 1 | Partial byte or overflow in the last message |
| msg_data | output | DEPTH*8 | Message buffer, byte k at bits 8k+7:8k |

## Verification
The bench targets four corner cases. The first is a trailing partial byte. A design that keeps the partial byte would report a count one too high, or would leave the error flag clear. The second is a ten-byte message. Here a missing saturation would wrap the count or overwrite the first stored bytes. The third is a request edge repeated inside an open message. A design that restarts on it would lose the bytes already received. The fourth is a set of transfer-clock and ready pulses sent while no message is open. A receiver that is not gated by the open state would leave stale bits in the next byte, or would raise a spurious completion.

// File: rtl/scr_pkg.sv
package scr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_OPEN = 1'b1
  } rx_state_e;
endpackage

// File: rtl/scr_sync.sv
module scr_sync #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_in,
  output logic [N-1:0] sync_out
);
  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_bit
      logic meta_q;
      logic stab_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          meta_q <= 1'b0;
          stab_q <= 1'b0;
        end else begin
          meta_q <= async_in[g];
          stab_q <= meta_q;
        end
      end
      assign sync_out[g] = stab_q;
    end
  endgenerate
endmodule

// File: rtl/scr_shifter.sv
module scr_shifter #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic             bit_in,
  output logic [WIDTH-1:0] byte_val,
  output logic             byte_stb,
  output logic             partial
);
  localparam int BIT_W = $clog2(WIDTH);
  localparam logic [BIT_W-1:0] LAST = BIT_W'(WIDTH - 1);

  logic [WIDTH-2:0] sreg_q, sreg_d;
  logic [BIT_W-1:0] cnt_q, cnt_d;
  logic             sreg_en;

  assign sreg_en  = clr | shift_en;
  assign byte_val = {sreg_q, bit_in};
  assign byte_stb = shift_en & ~clr & (cnt_q == LAST);
  assign partial  = (cnt_q != '0);

  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    if (clr) begin
      sreg_d = '0;
      cnt_d  = '0;
    end else if (shift_en) begin
      sreg_d = {sreg_q[WIDTH-3:0], bit_in};
      cnt_d  = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else if (sreg_en) begin
      sreg_q <= sreg_d;
      cnt_q  <= cnt_d;
    end
  end

  // R2
  bit_count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !clr) |=> $stable(cnt_q));
endmodule

// File: rtl/scr_bytebuf.sv
module scr_bytebuf #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     wr_en,
  input  logic [WIDTH-1:0]         wr_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                     ovf,
  output logic [DEPTH*WIDTH-1:0]   flat
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             room;
  logic             cnt_en;

  assign room   = (cnt_q != FULL);
  assign cnt_en = clr | wr_en;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (clr) begin
      cnt_d = '0;
      ovf_d = 1'b0;
    end else if (wr_en) begin
      if (room) cnt_d = cnt_q + 1'b1;
      else      ovf_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr && room) begin
      mem_q[cnt_q[IDX_W-1:0]] <= wr_data;
    end
  end

  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_flat
      assign flat[g*WIDTH +: WIDTH] = mem_q[g];
    end
  endgenerate

  assign count = cnt_q;
  assign ovf   = ovf_q;

  // R8
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL);
  // R8
  full_sets_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr && !room) |=> ovf_q);
endmodule

// File: rtl/cmd_serial_rx.sv
module cmd_serial_rx #(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       host_req,
  input  logic                       host_sclk,
  input  logic                       host_sdata,
  input  logic                       host_rdy,
  output logic                       host_ack,
  output logic                       msg_done,
  output logic [$clog2(DEPTH+1)-1:0] msg_len,
  output logic                       msg_err,
  output logic [DEPTH*8-1:0]         msg_data
);
  import scr_pkg::*;

  localparam int WIDTH = 8;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int I_DAT = 0;
  localparam int I_SCK = 1;
  localparam int I_REQ = 2;
  localparam int I_RDY = 3;

  logic [3:0]       lvl;
  logic [3:1]       prev_q;
  logic             sck_rise, req_rise, rdy_rise;
  rx_state_e        state_q, state_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] len_q, len_d;
  logic             err_q, err_d;
  logic             open_clr, shift_en;
  logic [WIDTH-1:0] byte_val;
  logic             byte_stb, partial;
  logic [CNT_W-1:0] buf_cnt;
  logic             buf_ovf;
  logic             res_en;

  scr_sync #(.N(4)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({host_rdy, host_req, host_sclk, host_sdata}),
    .sync_out (lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl[3:1];
  end

  assign sck_rise = lvl[I_SCK] & ~prev_q[I_SCK];
  assign req_rise = lvl[I_REQ] & ~prev_q[I_REQ];
  assign rdy_rise = lvl[I_RDY] & ~prev_q[I_RDY];

  assign open_clr = (state_q == ST_IDLE) & req_rise;
  assign shift_en = (state_q == ST_OPEN) & sck_rise & ~rdy_rise;

  scr_shifter #(.WIDTH(WIDTH)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (open_clr),
    .shift_en (shift_en),
    .bit_in   (lvl[I_DAT]),
    .byte_val (byte_val),
    .byte_stb (byte_stb),
    .partial  (partial)
  );

  scr_bytebuf #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (open_clr),
    .wr_en   (byte_stb),
    .wr_data (byte_val),
    .count   (buf_cnt),
    .ovf     (buf_ovf),
    .flat    (msg_data)
  );

  always_comb begin
    state_d = state_q;
    done_d  = 1'b0;
    len_d   = len_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE: if (req_rise) state_d = ST_OPEN;
      ST_OPEN: if (rdy_rise) begin
        state_d = ST_IDLE;
        done_d  = 1'b1;
        len_d   = buf_cnt;
        err_d   = buf_ovf | partial;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign res_en = done_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      len_q <= '0;
      err_q <= 1'b0;
    end else if (res_en) begin
      len_q <= len_d;
      err_q <= err_d;
    end
  end

  assign host_ack = (state_q == ST_OPEN);
  assign msg_done = done_q;
  assign msg_len  = len_q;
  assign msg_err  = err_q;

  // R5
  done_closes_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |-> (!host_ack && $past(host_ack)));
  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_done |=> !msg_done);
  // R6
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_len <= CNT_W'(DEPTH));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_done |-> ($stable(msg_len) && $stable(msg_err)));
  // R4
  idle_no_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_ack |-> !shift_en);
endmodule

// File: tb/cmd_serial_rx_tb_top.sv
module cmd_serial_rx_tb_top;
  localparam int DEPTH = 8;
  localparam int CNT_W = $clog2(DEPTH+1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_req = 1'b0, host_sclk = 1'b0, host_sdata = 1'b0, host_rdy = 1'b0;
  logic host_ack, msg_done, msg_err;
  logic [CNT_W-1:0] msg_len;
  logic [DEPTH*8-1:0] msg_data;

  always #4 clk = ~clk;

  cmd_serial_rx #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_sclk(host_sclk),
    .host_sdata(host_sdata), .host_rdy(host_rdy), .host_ack(host_ack),
    .msg_done(msg_done), .msg_len(msg_len), .msg_err(msg_err), .msg_data(msg_data)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  // behavioural reference model
  bit q_req[$], q_sck[$], q_dat[$], q_rdy[$];
  bit m_open, e_ack, e_done, e_err;
  int e_len, bits, cur;
  int got[$];
  int e_bytes[$];

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    q_req = '{0,0,0}; q_sck = '{0,0,0}; q_dat = '{0,0,0}; q_rdy = '{0,0,0};
    m_open = 0; e_ack = 0; e_done = 0; e_err = 0; e_len = 0; bits = 0; cur = 0;
    got.delete(); e_bytes.delete();
  endtask

  initial model_reset();

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) model_reset();
    else begin
      bit rq, rs, rr;
      rq = q_req[1] && !q_req[2];
      rs = q_sck[1] && !q_sck[2];
      rr = q_rdy[1] && !q_rdy[2];
      e_done = 0;
      if (m_open) begin
        if (rr) begin
          m_open = 0; e_ack = 0; e_done = 1;
          e_len = (got.size() > DEPTH) ? DEPTH : got.size();
          e_err = (bits != 0) || (got.size() > DEPTH);
          e_bytes = got;
        end else if (rs) begin
          cur = cur * 2 + int'(q_dat[1]);
          bits++;
          if (bits == 8) begin got.push_back(cur); bits = 0; cur = 0; end
        end
      end else if (rq) begin
        m_open = 1; e_ack = 1; bits = 0; cur = 0; got.delete();
      end
      q_req.push_front(host_req); void'(q_req.pop_back());
      q_sck.push_front(host_sclk); void'(q_sck.pop_back());
      q_dat.push_front(host_sdata); void'(q_dat.pop_back());
      q_rdy.push_front(host_rdy); void'(q_rdy.pop_back());
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R3 host_ack", int'(host_ack), int'(e_ack));
      chk("R5/R10 msg_done", int'(msg_done), int'(e_done));
      chk("R6/R9 msg_len", int'(msg_len), e_len);
      chk("R7/R8/R9 msg_err", int'(msg_err), int'(e_err));
      if (e_done) begin
        for (int k = 0; k < e_len; k++)
          chk("R2 msg_data byte", int'(msg_data[8*k +: 8]), e_bytes[k]);
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(bit b);
    host_sdata = b; host_sclk = 1'b0; wait_n(3);
    host_sclk = 1'b1; wait_n(3);
    host_sclk = 1'b0;
  endtask

  task automatic send_byte(int v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic open_msg();
    host_req = 1'b1; wait_n(5);
  endtask

  task automatic close_msg();
    wait_n(2); host_rdy = 1'b1; wait_n(3);
    host_rdy = 1'b0; host_req = 1'b0; wait_n(6);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 100000 && !finished) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
      finish_run();
    end
  end

  initial begin
    wait_n(4);
    // R1: reset values while held in reset
    chk("R1 ack in reset", int'(host_ack), 0);
    chk("R1 done in reset", int'(msg_done), 0);
    chk("R1 len in reset", int'(msg_len), 0);
    chk("R1 err in reset", int'(msg_err), 0);
    rst_n = 1'b1; wait_n(4);

    // R2 R3 R5 R6: three bytes
    open_msg(); send_byte(8'hA5); send_byte(8'h3C); send_byte(8'hFF); close_msg();

    // R4: repeated request edge inside a message
    open_msg(); send_byte(8'h81);
    host_req = 1'b0; wait_n(4); host_req = 1'b1; wait_n(4);
    send_byte(8'h7E); close_msg();

    // R4: transfer clocks while idle, then a clean message
    send_bit(1); send_bit(1); send_bit(0); wait_n(4);
    open_msg(); send_byte(8'h12); send_byte(8'h34); close_msg();

    // R10: ready while idle
    host_rdy = 1'b1; wait_n(3); host_rdy = 1'b0; wait_n(6);

    // R7: trailing partial byte
    open_msg(); send_byte(8'hC3); send_bit(1); send_bit(0); send_bit(1); close_msg();

    // R8: overflow with ten bytes
    open_msg();
    for (int i = 0; i < 10; i++) send_byte(8'h10 + i * 17);
    close_msg();

    // R6: exactly full buffer
    open_msg();
    for (int i = 0; i < DEPTH; i++) send_byte(8'hF0 - i * 3);
    close_msg();

    // R6: empty message
    open_msg(); close_msg();

    wait_n(10);
    finish_run();
  end
endmodule